// File: doc/BRIEF.md
# Edge-Latched Interrupt Collector

This block gathers interrupt requests from seven single-bit sources into one interrupt line. Four of the sources are a designated bit of each of four digital I/O groups. The other three are the final-stage output of each of three counter groups. Each source input passes through a synchronizer. A rising edge on a source whose own enable is high is then held in a sticky per-source flag. The shared interrupt output is raised while interrupts are globally enabled and at least one flag is held.

Software controls the block through two register offsets. Any write to the arm offset (0x1F) clears every flag and turns interrupts on. Any write to the disarm offset (0x1E) clears every flag and turns interrupts off. A read from either offset returns the same status byte: one bit per source, with the global enable state in the top bit. Flags keep collecting edges while interrupts are off. Interrupts start out disabled after reset.

Top module: `irq_edge_collector`

## Requirements
- R1: After a synchronous active-low reset, the status byte reads 0x00 and `irq` is low.
- R2: Status bit i (i = 0..6) is the flag of `src_in[i]`. Bits 0 to 3 belong to the four I/O groups and bits 4 to 6 belong to the three counter groups. Bit 7 is the global enable.
- R3: Suppose `src_in[i]` is first sampled high at clock edge k after being sampled low. Its flag then becomes visible after edge k+2 and not before.
- R4: A flag stays set when its source falls or stays high, until a clear write. A falling edge never sets a flag.
- R5: An edge that arrives while `src_en[i]` is low is not captured. Raising `src_en[i]` later while the source is still high does not set the flag either.
- R6: A write of any kind to offset 0x1F clears all flags and sets the global enable (status 0x80).
- R7: A write of any kind to offset 0x1E clears all flags and clears the global enable (status 0x00).
- R8: A read (`bus_rd` high) at offset 0x1E or 0x1F returns the same status byte in the same cycle. A read at any other offset returns 0x00.
- R9: `irq` is high exactly when the global enable is set and at least one flag is set.
- R10: Flags capture edges while the global enable is clear, and `irq` stays low during that time.
- R11: An edge that would set a flag at the same clock edge as a clear write is kept. The flag reads as set after that write.
- R12: Writes to offsets other than 0x1E and 0x1F change neither the flags nor the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 7 | Asynchronous source request lines |
| src_en | input | 7 | Per-source capture enable |
| bus_addr | input | 5 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access; the data value is irrelevant |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | 8 | Status byte while reading a status offset, else zero |
| irq | output | 1 | Aggregated interrupt request |

## Verification
The bench goes after the exact capture latency. A design with one synchronizer stage too few or too many would show the flag one read early or one read late. It also targets an edge that lands on the same clock edge as a clear write. A design that lets the clear win would read zero where the bench expects the bit. The bench also checks stale levels: a source held high while its enable is raised must not set its flag, or the design is capturing levels rather than edges. The remaining checks cover capture while disarmed, where a leaky design would raise `irq`, and writes to unrelated offsets, where a loose decoder would clear or arm the block.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the interrupt collector.
// Assumes: a single register access per cycle.
package irqc_pkg;

    // Kind of control access decoded from one bus write.
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_ARM    = 2'd1,
        ACC_DISARM = 2'd2
    } acc_cmd_e;

endpackage

// File: rtl/irqc_sync.sv
`timescale 1ns/1ps
// Module: irqc_sync
// Purpose: resynchronizes W asynchronous lines into the clk domain
// through a chain of STAGES flops.
// Assumes: each source is a level that stays put for several clocks,
// so per-bit skew between lines is harmless.
module irqc_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    // Shift every line one flop further down the chain each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irqc_edge_latch.sv
`timescale 1ns/1ps
// Module: irqc_edge_latch
// Purpose: per-source rising-edge detect and sticky flag.
// Assumes: inputs are already synchronous. A clear and a fresh edge in
// the same cycle leave the flag set, so no edge is lost.
module irqc_edge_latch #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] en_i,
    input  logic         clr_i,
    output logic [W-1:0] flag_o
);

    for (genvar i = 0; i < W; i++) begin : g_src
        logic prev_q;
        logic flag_q;
        logic rise;

        assign rise = sync_i[i] & ~prev_q;

        // Remember last synchronous level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= sync_i[i];
        end

        // Set on enabled rising edge; clear on request; edge wins a tie.
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= (flag_q & ~clr_i) | (rise & en_i[i]);
        end

        assign flag_o[i] = flag_q;
    end

endmodule

// File: rtl/irqc_regif.sv
`timescale 1ns/1ps
// Module: irqc_regif
// Purpose: decodes the arm/disarm offsets, owns the global enable and
// returns the status byte on reads of either offset.
// Assumes: write data carries no meaning; only the offset matters.
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int                N          = 7,
    parameter int                ADDR_W     = 5,
    parameter logic [ADDR_W-1:0] ARM_OFS    = 5'h1F,
    parameter logic [ADDR_W-1:0] DISARM_OFS = 5'h1E,
    localparam int               STAT_W     = N + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      flag_i,
    output logic              clr_o,
    output logic              armed_o,
    output logic [STAT_W-1:0] rd_data_o
);

    acc_cmd_e cmd;
    logic     armed_q;
    logic     stat_hit;

    // Classify the current write into arm, disarm or nothing.
    always_comb begin
        cmd = ACC_NONE;
        if (bus_wr) begin
            if (bus_addr == ARM_OFS)         cmd = ACC_ARM;
            else if (bus_addr == DISARM_OFS) cmd = ACC_DISARM;
        end
    end

    // Global enable: set by arm, cleared by disarm, off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            case (cmd)
                ACC_ARM:    armed_q <= 1'b1;
                ACC_DISARM: armed_q <= 1'b0;
                default:    armed_q <= armed_q;
            endcase
        end
    end

    assign clr_o    = (cmd != ACC_NONE);
    assign armed_o  = armed_q;
    assign stat_hit = (bus_addr == ARM_OFS) || (bus_addr == DISARM_OFS);

    // Status read mux: both offsets alias the same byte.
    always_comb begin
        rd_data_o = '0;
        if (bus_rd && stat_hit) rd_data_o = {armed_q, flag_i};
    end

endmodule

// File: rtl/irq_edge_collector.sv
`timescale 1ns/1ps
// Module: irq_edge_collector (top)
// Purpose: synchronizes N source lines, latches enabled rising edges and
// drives one interrupt line gated by a software-controlled enable.
// Assumes: sources are low during reset; one bus access per cycle.
module irq_edge_collector #(
    parameter int                N_SRC       = 7,
    parameter int                ADDR_W      = 5,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] ARM_OFS     = 5'h1F,
    parameter logic [ADDR_W-1:0] DISARM_OFS  = 5'h1E,
    localparam int               STAT_W      = N_SRC + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic [N_SRC-1:0]  src_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [STAT_W-1:0] rd_data,
    output logic              irq
);

    logic [N_SRC-1:0] src_sync;
    logic [N_SRC-1:0] flag_vec;
    logic             clr_all;
    logic             armed;

    irqc_sync #(
        .W      (N_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_in),
        .sync_o  (src_sync)
    );

    irqc_edge_latch #(
        .W (N_SRC)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (src_sync),
        .en_i   (src_en),
        .clr_i  (clr_all),
        .flag_o (flag_vec)
    );

    irqc_regif #(
        .N          (N_SRC),
        .ADDR_W     (ADDR_W),
        .ARM_OFS    (ARM_OFS),
        .DISARM_OFS (DISARM_OFS)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .flag_i    (flag_vec),
        .clr_o     (clr_all),
        .armed_o   (armed),
        .rd_data_o (rd_data)
    );

    // Interrupt line: any held flag, only while armed.
    assign irq = armed & (|flag_vec);

endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
// Module: irqc_checker
// Purpose: temporal properties of the collector, bound onto the top.
// Assumes: flag and armed are the internal state of the bound instance.
module irqc_checker #(
    parameter int                N          = 7,
    parameter int                ADDR_W     = 5,
    parameter logic [ADDR_W-1:0] ARM_OFS    = 5'h1F,
    parameter logic [ADDR_W-1:0] DISARM_OFS = 5'h1E
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      src_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              irq,
    input logic [N-1:0]      flag,
    input logic              armed
);

    logic rst_seen_q;
    logic wr_arm;
    logic wr_disarm;

    assign wr_arm    = bus_wr && (bus_addr == ARM_OFS);
    assign wr_disarm = bus_wr && (bus_addr == DISARM_OFS);

    // Track whether the previous edge was in reset.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R1: state right after reset is quiet.
    always @(posedge clk) begin
        if (rst_seen_q) begin
            p_reset_quiet_r1: assert (!armed && flag == '0 && !irq);
        end
    end

    // R9 / R10: interrupt line never high while disarmed or with no flag.
    p_irq_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (armed && flag != '0));

    // R6: arm write enables next cycle.
    p_arm_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_arm |=> armed);

    // R7: disarm write disables next cycle.
    p_disarm_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_disarm |=> !armed);

    // R4: without a clear, no flag ever drops.
    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_arm || wr_disarm) |=> ((flag & $past(flag)) == $past(flag)));

    // R5: a newly set flag needs its enable in the previous cycle.
    p_gate_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag & ~$past(flag) & ~$past(src_en)) == '0));

    // R12: other accesses leave the global enable alone.
    p_enable_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_arm || wr_disarm) |=> (armed == $past(armed)));

endmodule

bind irq_edge_collector irqc_checker #(
    .N          (N_SRC),
    .ADDR_W     (ADDR_W),
    .ARM_OFS    (ARM_OFS),
    .DISARM_OFS (DISARM_OFS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_en   (src_en),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .irq      (irq),
    .flag     (flag_vec),
    .armed    (armed)
);

// File: tb/irq_edge_collector_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected status/irq, a monitor
// compares them one nanosecond after the falling edge of the read cycle.
module irq_edge_collector_tb;

    localparam logic [4:0] A_ARM = 5'h1F;
    localparam logic [4:0] A_DIS = 5'h1E;

    typedef struct {
        logic [7:0] data;
        logic       irq;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src_in = '0;
    logic [6:0] src_en = '0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    irq_edge_collector u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .src_en   (src_en),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .rd_data  (rd_data),
        .irq      (irq)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] d,
                      input logic i, input string tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        q.push_back('{data: d, irq: i, tag: tag});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a);
        bus_addr = a;
        bus_wr   = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Monitor: compare each read cycle against the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_rd) begin
                item_t it;
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard empty: actual %02h expected item", rd_data);
                end else begin
                    it = q.pop_front();
                    if (rd_data !== it.data || irq !== it.irq) begin
                        errors++;
                        $display("FAIL %s: actual data=%02h irq=%b expected data=%02h irq=%b",
                                 it.tag, rd_data, irq, it.data, it.irq);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(5);
        rst_n = 1'b1;
        rd(A_ARM, 8'h00, 1'b0, "R1 reset status at arm offset");
        rd(A_DIS, 8'h00, 1'b0, "R1 reset status at disarm offset");
        rd(5'h03, 8'h00, 1'b0, "R8 unrelated offset reads zero");

        src_en = 7'h7F;
        // R3 latency: raise at N0, flag absent at N2, present at N3.
        src_in[0] = 1'b1;
        step(2);
        rd(A_ARM, 8'h00, 1'b0, "R3 flag not yet visible");
        rd(A_ARM, 8'h01, 1'b0, "R3 R10 flag visible, irq low disarmed");

        src_in[0] = 1'b0;
        step(4);
        rd(A_ARM, 8'h01, 1'b0, "R4 flag held after source falls");

        wr(A_ARM);
        rd(A_ARM, 8'h80, 1'b0, "R6 arm write clears and enables");

        src_in[5] = 1'b1;
        step(3);
        rd(A_ARM, 8'hA0, 1'b1, "R2 R9 counter source bit 5 raises irq");
        rd(A_DIS, 8'hA0, 1'b1, "R8 disarm offset aliases status");

        wr(A_ARM);
        src_in[5] = 1'b0;
        step(4);
        rd(A_ARM, 8'h80, 1'b0, "R4 falling edge sets nothing");

        src_en[3] = 1'b0;
        src_in[3] = 1'b1;
        step(4);
        rd(A_ARM, 8'h80, 1'b0, "R5 masked source edge dropped");
        src_en[3] = 1'b1;
        step(4);
        rd(A_ARM, 8'h80, 1'b0, "R5 enabling over a high level captures nothing");
        src_in[3] = 1'b0;

        src_in[1] = 1'b1;
        step(3);
        rd(A_ARM, 8'h82, 1'b1, "R9 I/O group bit 1 raises irq");
        wr(5'h10);
        wr(5'h1D);
        rd(A_ARM, 8'h82, 1'b1, "R12 writes to other offsets ignored");

        wr(A_DIS);
        rd(A_DIS, 8'h00, 1'b0, "R7 disarm write clears and disables");

        src_in[6] = 1'b1;
        step(3);
        rd(A_ARM, 8'h40, 1'b0, "R10 capture while disarmed, irq low");

        // R11: edge sets flag at the same clock edge as the arm write.
        src_in[2] = 1'b1;
        step(2);
        wr(A_ARM);
        rd(A_ARM, 8'h84, 1'b1, "R11 edge survives concurrent arm clear");

        src_in[2] = 1'b0;
        step(4);
        src_in[2] = 1'b1;
        step(2);
        wr(A_DIS);
        rd(A_ARM, 8'h04, 1'b0, "R11 edge survives concurrent disarm clear");

        src_in = '0;
        step(4);
        wr(A_DIS);
        rd(A_DIS, 8'h00, 1'b0, "R7 clear before full map test");
        src_in = 7'h7F;
        step(3);
        rd(A_DIS, 8'h7F, 1'b0, "R2 every source maps to its own bit");
        wr(A_ARM);
        rd(A_DIS, 8'h80, 1'b0, "R6 arm clears full map");

        step(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule